// File: doc/BRIEF.md
# Decimating Low-Pass FIR Filter with Shared Multipliers

This block is a low-pass FIR filter that reduces the sample rate by four. Signed 16-bit samples arrive with a valid strobe and enter a delay line on every accepted sample. On every fourth accepted sample the block freezes the current window of samples. It then computes one filtered output sample, rounds it to 16 bits, saturates it, and presents it with a one-cycle valid strobe.

The filter does not use one multiplier per tap. Each multiply-accumulate unit serves three taps, one tap per clock cycle, over three consecutive cycles. The number of units is the tap count divided by three, rounded up. Slots in the last unit that have no tap behind them add zero.

The coefficients come from a register array kept outside this block by a configuration block. They reach this block as one flat port. Each coefficient is a 24-bit two's-complement fixed-point value.

Top module: `decim_fir`

## Requirements
- R1: A sample is accepted only in a cycle where `sampleValid` is high. While `sampleValid` is low, `sampleIn` has no effect on any later output.
- R2: Accepted samples are counted from reset. An output is produced only after each 4th, 8th, 12th, … accepted sample, and never after any other accepted sample.
- R3: Each output equals the sum over k of coefficient k times x[n−k]. Here x[n] is the accepted sample that triggered the output, x[n−1] is the one accepted before it, and so on. Coefficient k sits in `coefFlat[24k+23:24k]`, so coefficient 0 multiplies the newest sample.
- R4: A coefficient is 24-bit two's complement with 20 fractional bits. Its value runs from −8.0 (0x800000) up to 8 − 2^−20 (0x7FFFFF), and both extremes are used at full value.
- R5: The exact sum is rounded to an integer by adding one half and taking the floor. So +1.5 becomes 2, −1.5 becomes −1, −0.25 becomes 0 and −0.75 becomes −1.
- R6: A rounded result above 32767 is output as 32767. A rounded result below −32768 is output as −32768.
- R7: `outValid` is high for exactly one cycle. It rises on the 4th clock edge after the edge that accepted the triggering sample. `outSample` changes only at that edge and then holds its value.
- R8: Samples may be accepted on every cycle without any gap. Each multiply-accumulate unit walks through its three taps in three consecutive cycles, starting the cycle after the triggering sample. Tap slots beyond the tap count add zero.
- R9: After reset, `outValid` is 0, `outSample` is 0, the sample count restarts from zero and the delay line holds zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | Accept `sampleIn` in this cycle |
| sampleIn | input | SW (16) | Signed input sample |
| coefFlat | input | NTAPS*CW (12*24) | Coefficients; coefficient k in bits [24k+23:24k] |
| outValid | output | 1 | One-cycle strobe marking a new output |
| outSample | output | SW (16) | Signed filtered, decimated output |

## Verification
The bench builds the block with NTAPS = 4 and a decimation of four. This gives two multiply-accumulate units, the second using one of its three slots, so the zero contribution of the unused slots is exercised. Because four taps match the decimation factor, each output depends only on the latest group of four samples. Every table row is therefore a self-contained group whose result can be worked out by hand, including half-way rounding in both signs and saturation at both rails. The coefficients are then set to the −8 and just-under-+8 extremes, samples are streamed on every cycle, and reset is applied in the middle of a group, which checks that the sample count restarts.

// File: rtl/fir_pkg.sv
package fir_pkg;

  // Architectural constant: every shared multiplier serves this many taps.
  localparam int TAPS_PER_MAC = 3;
  localparam int TSEL_W       = $clog2(TAPS_PER_MAC);

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic              shift;     // accept sample into the delay line
    logic              snap;      // freeze the window for a new output
    logic              macEn;     // multiply-accumulate step active
    logic              macFirst;  // first step: load instead of add
    logic [TSEL_W-1:0] tapSel;    // which of the three slots is used
    logic              finish;    // sum units, round, saturate, emit
  } fir_strb_t;

endpackage

// File: rtl/fir_ctrl.sv
module fir_ctrl
  import fir_pkg::*;
#(
  parameter int DECIM = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleValid,
  output fir_strb_t strb
);

  localparam int PHW = $clog2(DECIM);
  localparam logic [PHW-1:0]    LAST_PHASE = PHW'(DECIM - 1);
  localparam logic [TSEL_W-1:0] LAST_TAP   = TSEL_W'(TAPS_PER_MAC - 1);

  logic [PHW-1:0]    phase;
  logic              macActive;
  logic [TSEL_W-1:0] tapSel;
  logic              finishQ;
  logic              start;

  assign start = sampleValid && (phase == LAST_PHASE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= '0;
      macActive <= 1'b0;
      tapSel    <= '0;
      finishQ   <= 1'b0;
    end else begin
      if (sampleValid) begin
        phase <= (phase == LAST_PHASE) ? '0 : phase + 1'b1;
      end
      finishQ <= macActive && (tapSel == LAST_TAP);
      if (start) begin
        macActive <= 1'b1;
        tapSel    <= '0;
      end else if (macActive) begin
        if (tapSel == LAST_TAP) begin
          macActive <= 1'b0;
        end else begin
          tapSel <= tapSel + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strb.shift    = sampleValid;
    strb.snap     = start;
    strb.macEn    = macActive;
    strb.macFirst = (tapSel == '0);
    strb.tapSel   = tapSel;
    strb.finish   = finishQ;
  end

endmodule

// File: rtl/fir_mac.sv
module fir_mac
  import fir_pkg::*;
#(
  parameter int SW   = 16,
  parameter int CW   = 24,
  parameter int ACCW = 44
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          en,
  input  logic                          first,
  input  logic [TSEL_W-1:0]             tapSel,
  input  logic [TAPS_PER_MAC*SW-1:0]    smpVec,
  input  logic [TAPS_PER_MAC*CW-1:0]    coefVec,
  output logic signed [ACCW-1:0]        acc
);

  localparam int PW = SW + CW;

  logic signed [SW-1:0] selSmp;
  logic signed [CW-1:0] selCoef;
  logic signed [PW-1:0] prod;

  always_comb begin
    selSmp  = $signed(smpVec[tapSel*SW +: SW]);
    selCoef = $signed(coefVec[tapSel*CW +: CW]);
    prod    = PW'(selSmp) * PW'(selCoef);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0;
    end else if (en) begin
      acc <= first ? ACCW'(prod) : acc + ACCW'(prod);
    end
  end

endmodule

// File: rtl/fir_datapath.sv
module fir_datapath
  import fir_pkg::*;
#(
  parameter int NTAPS = 12,
  parameter int SW    = 16,
  parameter int CW    = 24,
  parameter int CFRAC = 20
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [SW-1:0]         sampleIn,
  input  logic [NTAPS*CW-1:0]   coefFlat,
  input  fir_strb_t             strb,
  output logic [SW-1:0]         outSample,
  output logic                  outValid
);

  localparam int NMAC  = (NTAPS + TAPS_PER_MAC - 1) / TAPS_PER_MAC;
  localparam int NSLOT = NMAC * TAPS_PER_MAC;
  localparam int PW    = SW + CW;
  localparam int ACCW  = PW + $clog2(NSLOT) + 1;
  localparam logic signed [ACCW-1:0] HALF = ACCW'(2 ** (CFRAC - 1));
  localparam logic signed [ACCW-1:0] MAXV = ACCW'((2 ** (SW - 1)) - 1);
  localparam logic signed [ACCW-1:0] MINV = -MAXV - 1;

  logic signed [SW-1:0]   dly     [NTAPS-1];
  logic signed [SW-1:0]   win     [NTAPS];
  logic signed [SW-1:0]   snap    [NSLOT];
  logic signed [CW-1:0]   coefSl  [NSLOT];
  logic signed [ACCW-1:0] macAcc  [NMAC];
  logic signed [ACCW-1:0] total;
  logic signed [ACCW-1:0] rnd;

  // Delay line: shifts on every accepted sample.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NTAPS - 1; i++) dly[i] <= '0;
    end else if (strb.shift) begin
      dly[0] <= $signed(sampleIn);
      for (int i = 1; i < NTAPS - 1; i++) dly[i] <= dly[i-1];
    end
  end

  // Window as it stands after the current sample is accepted.
  always_comb begin
    win[0] = $signed(sampleIn);
    for (int i = 1; i < NTAPS; i++) win[i] = dly[i-1];
  end

  // Per-slot frozen sample and coefficient; unused slots hold zero.
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    if (s < NTAPS) begin : g_live
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          snap[s] <= '0;
        else if (strb.snap) snap[s] <= win[s];
      end
      assign coefSl[s] = $signed(coefFlat[s*CW +: CW]);
    end else begin : g_pad
      assign snap[s]   = '0;
      assign coefSl[s] = '0;
    end
  end

  // Shared multipliers, each serving three consecutive slots.
  for (genvar m = 0; m < NMAC; m++) begin : g_mac
    logic [TAPS_PER_MAC*SW-1:0] smpVec;
    logic [TAPS_PER_MAC*CW-1:0] coefVec;
    for (genvar t = 0; t < TAPS_PER_MAC; t++) begin : g_pack
      assign smpVec[t*SW +: SW]  = snap[m*TAPS_PER_MAC + t];
      assign coefVec[t*CW +: CW] = coefSl[m*TAPS_PER_MAC + t];
    end
    fir_mac #(.SW(SW), .CW(CW), .ACCW(ACCW)) i_mac (
      .clk     (clk),
      .rstN    (rstN),
      .en      (strb.macEn),
      .first   (strb.macFirst),
      .tapSel  (strb.tapSel),
      .smpVec  (smpVec),
      .coefVec (coefVec),
      .acc     (macAcc[m])
    );
  end

  always_comb begin
    total = '0;
    for (int m = 0; m < NMAC; m++) total = total + macAcc[m];
    rnd = (total + HALF) >>> CFRAC;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outSample <= '0;
      outValid  <= 1'b0;
    end else begin
      outValid <= strb.finish;
      if (strb.finish) begin
        if (rnd > MAXV)      outSample <= MAXV[SW-1:0];
        else if (rnd < MINV) outSample <= MINV[SW-1:0];
        else                 outSample <= rnd[SW-1:0];
      end
    end
  end

endmodule

// File: rtl/decim_fir.sv
module decim_fir
  import fir_pkg::*;
#(
  parameter int NTAPS = 12,
  parameter int DECIM = 4,
  parameter int SW    = 16,
  parameter int CW    = 24,
  parameter int CFRAC = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SW-1:0]       sampleIn,
  input  logic [NTAPS*CW-1:0] coefFlat,
  output logic                outValid,
  output logic [SW-1:0]       outSample
);

  fir_strb_t strb;

  fir_ctrl #(.DECIM(DECIM)) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .strb        (strb)
  );

  fir_datapath #(.NTAPS(NTAPS), .SW(SW), .CW(CW), .CFRAC(CFRAC)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sampleIn  (sampleIn),
    .coefFlat  (coefFlat),
    .strb      (strb),
    .outSample (outSample),
    .outValid  (outValid)
  );

endmodule

// File: rtl/fir_checker.sv
module fir_checker
  import fir_pkg::*;
#(
  parameter int SW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          sampleValid,
  input logic          outValid,
  input logic [SW-1:0] outSample,
  input fir_strb_t     strb
);

  // R7: the output strobe lasts a single cycle.
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R7 / R2: an output is always preceded, five samples back, by an accepted input.
  a_r7_latency: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(sampleValid, 5));

  // R7: the output value holds between strobes.
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outSample));

  // R8: a window freeze starts the tap walk at slot 0 on the next cycle.
  a_r8_walk_start: assert property (@(posedge clk) disable iff (!rstN)
    strb.snap |=> (strb.macEn && strb.macFirst));

  // R8: the tap walk never selects a slot outside the unit.
  a_r8_slot_range: assert property (@(posedge clk) disable iff (!rstN)
    strb.macEn |-> (strb.tapSel < TSEL_W'(TAPS_PER_MAC)));

  // R8: the walk continues until the last slot.
  a_r8_walk_cont: assert property (@(posedge clk) disable iff (!rstN)
    (strb.macEn && (strb.tapSel != TSEL_W'(TAPS_PER_MAC - 1))) |=> strb.macEn);

  // R2: a new output never starts while a walk is still running.
  a_r2_start_idle: assert property (@(posedge clk) disable iff (!rstN)
    strb.snap |-> !strb.macEn);

endmodule

bind decim_fir fir_checker #(.SW(SW)) i_fir_checker (
  .clk         (clk),
  .rstN        (rstN),
  .sampleValid (sampleValid),
  .outValid    (outValid),
  .outSample   (outSample),
  .strb        (strb)
);

// File: tb/test_decim_fir.sv
`timescale 1ns/1ps
module test_decim_fir;

  localparam int NTAPS = 4;
  localparam int CW    = 24;

  typedef struct packed {
    logic signed [15:0] x0;  // oldest of the group
    logic signed [15:0] x1;
    logic signed [15:0] x2;
    logic signed [15:0] x3;  // newest, triggers the output
    logic signed [15:0] y;   // expected output
  } vec_t;

  // Coefficients c0=1.0, c1=0.5, c2=-0.25, c3=2.0 (c0 on newest sample).
  // y = x3 + 0.5*x2 - 0.25*x1 + 2*x0, rounded half up, saturated.
  localparam vec_t VECS [11] = '{
    '{16'sd0,      16'sd0,     16'sd0,      16'sd100,   16'sd100},   // R3
    '{16'sd10,     16'sd0,     16'sd0,      16'sd0,     16'sd20},    // R3
    '{16'sd0,      16'sd0,     16'sd3,      16'sd0,     16'sd2},     // R5 +1.5
    '{16'sd0,      16'sd0,    -16'sd3,      16'sd0,    -16'sd1},     // R5 -1.5
    '{16'sd0,      16'sd1,     16'sd0,      16'sd0,     16'sd0},     // R5 -0.25
    '{16'sd0,      16'sd3,     16'sd0,      16'sd0,    -16'sd1},     // R5 -0.75
    '{16'sd20000,  16'sd0,     16'sd0,      16'sd0,     16'sd32767}, // R6 high
    '{-16'sd20000, 16'sd0,     16'sd0,      16'sd0,    -16'sd32768}, // R6 low
    '{16'sd100,    16'sd200,   16'sd300,    16'sd400,   16'sd700},   // R3
    '{-16'sd32768, 16'sd32767, -16'sd32768, 16'sd32767, -16'sd32768},// R6
    '{16'sd1000,  -16'sd1000,  16'sd1000,  -16'sd1000,  16'sd1750}   // R3
  };

  logic                     clk = 1'b0;
  logic                     rstN = 1'b0;
  logic                     sampleValid = 1'b0;
  logic signed [15:0]       sampleIn = '0;
  logic [NTAPS*CW-1:0]      coefFlat;
  logic                     outValid;
  logic signed [15:0]       outSample;

  int nChecks = 0;
  int nFail   = 0;

  always #2 clk = ~clk;

  decim_fir #(.NTAPS(NTAPS), .DECIM(4), .SW(16), .CW(CW), .CFRAC(20)) i_decim_fir (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .sampleIn    (sampleIn),
    .coefFlat    (coefFlat),
    .outValid    (outValid),
    .outSample   (outSample)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one group of four samples, optionally with idle gaps carrying junk.
  task automatic runGroup(input vec_t v, input bit gap, input string tag);
    logic signed [15:0] xs [4];
    xs = '{v.x0, v.x1, v.x2, v.x3};
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); sampleValid = 1'b1; sampleIn = xs[k];
      if (gap && k < 3) begin
        @(negedge clk); sampleValid = 1'b0; sampleIn = 16'sh5A5A;  // R1 junk
      end
    end
    @(negedge clk); sampleValid = 1'b0; sampleIn = 16'sh7FFF;      // after edge T
    @(negedge clk);                                                // after T+1
    @(negedge clk);                                                // after T+2
    @(negedge clk); check("R7 no early valid", int'(outValid), 0); // after T+3
    @(negedge clk);                                                // after T+4
    check("R7 valid at latency 4", int'(outValid), 1);
    check(tag, int'(outSample), int'(v.y));
    @(negedge clk);
    check("R7 valid one cycle", int'(outValid), 0);
    check("R7 output holds", int'(outSample), int'(v.y));
  endtask

  initial begin
    #(4 * 200000);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    coefFlat = {24'h200000, 24'hFC0000, 24'h080000, 24'h100000};
    repeat (3) @(negedge clk);
    check("R9 reset outValid", int'(outValid), 0);
    check("R9 reset outSample", int'(outSample), 0);
    rstN = 1'b1;

    // Table walk: alternate gap-free and gapped groups (R1, R2, R3, R5, R6).
    for (int i = 0; i < 11; i++) begin
      runGroup(VECS[i], (i % 2) == 1, $sformatf("R3 R5 R6 row %0d", i));
    end

    // R8: stream two groups on consecutive cycles.
    begin
      logic signed [15:0] st [8];
      int spurious;
      st = '{VECS[8].x0, VECS[8].x1, VECS[8].x2, VECS[8].x3,
             VECS[10].x0, VECS[10].x1, VECS[10].x2, VECS[10].x3};
      spurious = 0;
      for (int j = 0; j < 14; j++) begin
        @(negedge clk);
        if (j == 8) begin
          check("R8 stream first valid", int'(outValid), 1);
          check("R8 stream first value", int'(outSample), int'(VECS[8].y));
        end else if (j == 12) begin
          check("R8 stream second valid", int'(outValid), 1);
          check("R8 stream second value", int'(outSample), int'(VECS[10].y));
        end else if (outValid) begin
          spurious++;
        end
        if (j < 8) begin sampleValid = 1'b1; sampleIn = st[j]; end
        else       begin sampleValid = 1'b0; sampleIn = 16'sh1234; end
      end
      check("R2 R8 no extra outputs", spurious, 0);
    end

    // R4: coefficient extremes on the newest-sample tap.
    coefFlat = {24'h000000, 24'h000000, 24'h000000, 24'h800000};
    runGroup('{16'sd0, 16'sd0, 16'sd0, 16'sd100, -16'sd800}, 1'b0, "R4 coef -8");
    runGroup('{16'sd0, 16'sd0, 16'sd0, -16'sd4096, 16'sd32767}, 1'b0, "R4 R6 coef -8 sat");
    coefFlat = {24'h000000, 24'h000000, 24'h000000, 24'h7FFFFF};
    runGroup('{16'sd0, 16'sd0, 16'sd0, 16'sd1000, 16'sd8000}, 1'b0, "R4 coef max");

    // R9: reset in the middle of a group restarts the sample count.
    coefFlat = {24'h200000, 24'hFC0000, 24'h080000, 24'h100000};
    @(negedge clk); sampleValid = 1'b1; sampleIn = 16'sd77;
    @(negedge clk); sampleValid = 1'b1; sampleIn = 16'sd88;
    @(negedge clk); sampleValid = 1'b0; rstN = 1'b0;
    @(negedge clk);
    check("R9 mid reset outValid", int'(outValid), 0);
    check("R9 mid reset outSample", int'(outSample), 0);
    rstN = 1'b1;
    runGroup(VECS[8], 1'b0, "R2 R9 count restarts");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule